// File: doc/BRIEF.md
# Indirect Trigger Memory Access Controller

This block holds the schedule table of a time-triggered CAN node: 32 trigger words of 32 bits each. The CPU cannot address this table directly. Instead it sees four 16-bit registers on its register bus: a control register and two data registers, plus one spare slot that reads zero. The control register holds a direction bit and an entry index. A write that touches the control register's low byte starts a transfer. The transfer moves one whole 32-bit word between the selected entry and the pair of data registers, in the direction the direction bit gives.

Transfers are permitted only while the controller is in configuration mode. While the `active_mode` input is high, the control register refuses writes. A transfer that reaches its execute cycle in active mode changes nothing. The schedule logic that consumes the triggers has its own read-only port. It presents an index and receives the stored word combinationally.

A transfer takes one clock. For that single cycle a busy flag reads 1 in the control register. The data registers stay readable and writable in every mode.

Top module: `tmac_top`

## Requirements
- R1: After a synchronous active-low reset, every bus register reads 0x0000 (control, upper data, lower data, and the unused slot at offset 3), and the busy flag is 0.
- R2: The control register (offset 0) reads with the direction bit at bit 15, busy at bit 14 and the entry index at bits 4:0. Bits 13:5 read 0.
- R3: A control write with byte enable 0 clear and byte enable 1 set updates only the direction bit. It starts no transfer: busy stays 0 and the data registers keep their values.
- R4: A control write with byte enable 0 set and direction 1 stores {upper data, lower data} into the indexed entry at the clock edge one cycle after the write edge.
- R5: A control write with byte enable 0 set and direction 0 loads the indexed entry into the data registers one cycle after the write edge: bits 31:16 go to the upper register (offset 1) and bits 15:0 to the lower register (offset 2).
- R6: Busy reads 1 for exactly the one cycle after a transfer-starting write, then reads 0 again.
- R7: While `active_mode` is high, control writes are ignored: the control value is unchanged and no transfer starts.
- R8: If `active_mode` is high in a transfer's execute cycle, neither the memory nor the data registers change.
- R9: Both data registers accept writes in both modes, with per-byte enables (bit 0 covers bits 7:0 and bit 1 covers bits 15:8).
- R10: `sch_word` returns the stored word of entry `sch_idx` combinationally. All 32 entries, 0x00 to 0x1F, are reachable.
- R11: The upper data register is laid out as trigger type in bits 15:12, message number in 11:6, a reserved bit 5 and cycle code in 4:0. The lower register is the 16-bit time mark. Bit 5 always reads 0.
- R12: Control writes that arrive while busy is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| active_mode | input | 1 | 1 = active mode (table locked), 0 = configuration mode |
| bus_sel | input | 1 | Register access strobe, one cycle per write |
| bus_wr | input | 1 | 1 = write access |
| bus_addr | input | 2 | Register offset: 0 control, 1 upper data, 2 lower data, 3 unused |
| bus_be | input | 2 | Byte enables for writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the register at `bus_addr`, combinational |
| sch_idx | input | 5 | Schedule-side entry index |
| sch_word | output | 32 | Stored word of entry `sch_idx` |

## Verification
The assertions assume `active_mode` and the bus inputs are settled at each rising edge, and that a write strobe lasts a single cycle. The stimulus changes every input only at falling edges and drops `bus_sel` in the cycle after each write. The memory-side checks assume the schedule port only reads entries that have already been written, because contents after reset are undefined. The stimulus therefore fills all 32 entries before it reads any of them through `sch_word`. The lock checks assume mode can change in any cycle. The stimulus raises `active_mode` both between transfers and in the middle of one.

// File: rtl/tmac_pkg.sv
// Package: shared constants and field positions for the trigger memory
// access controller. Assumes 16-bit CPU registers and 32-bit table words.
package tmac_pkg;
    localparam int REG_W    = 16;
    localparam int WORD_W   = 2 * REG_W;
    localparam int ADDR_W   = 2;

    typedef enum logic [ADDR_W-1:0] {
        OFS_CTRL  = 2'd0,
        OFS_UPPER = 2'd1,
        OFS_LOWER = 2'd2,
        OFS_SPARE = 2'd3
    } reg_ofs_e;

    // Control register bit positions
    localparam int CTL_DIR_BIT  = 15;
    localparam int CTL_BUSY_BIT = 14;

    // Upper data register: reserved bit that is never stored
    localparam int UPR_RSVD_BIT = 5;
    localparam logic [REG_W-1:0] UPR_KEEP_MASK = ~(REG_W'(1) << UPR_RSVD_BIT);
endpackage

// File: rtl/tmac_store.sv
// Module: tmac_store
// Trigger table storage: DEPTH words, one synchronous write port, two
// combinational read ports (transfer side and schedule side).
// Assumes: contents are not reset; the writer never asserts we while locked.
module tmac_store
    import tmac_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [WORD_W-1:0] wword,
    input  logic [IDX_W-1:0]  ridx_a,
    output logic [WORD_W-1:0] rword_a,
    input  logic [IDX_W-1:0]  ridx_b,
    output logic [WORD_W-1:0] rword_b
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Per-entry write enable and storage, one generate slice per entry
    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (we && widx == IDX_W'(e)) mem[e] <= wword;
        end
    end

    // Combinational read ports
    assign rword_a = mem[ridx_a];
    assign rword_b = mem[ridx_b];

    // R8: no table write may occur while the lock is held
    p_no_write_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !lock)
        else $error("table written while locked");
endmodule

// File: rtl/tmac_seq.sv
// Module: tmac_seq
// Transfer sequencer: turns a start pulse into one busy cycle. At the end of
// that cycle it issues a table write or a data-register load.
// Assumes: direction and index hold steady while busy (control is frozen then).
module tmac_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic dir,
    input  logic active_mode,
    output logic busy,
    output logic mem_we,
    output logic ld_en
);
    // One-cycle busy flag following each start
    always_ff @(posedge clk) begin
        if (!rst_n) busy <= 1'b0;
        else        busy <= start;
    end

    // Execute strobes, suppressed when active mode is seen in the execute cycle
    always_comb begin
        mem_we = busy &&  dir && !active_mode;
        ld_en  = busy && !dir && !active_mode;
    end

    // R6: busy never lasts longer than one cycle
    p_busy_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy)
        else $error("busy held for two cycles");
endmodule

// File: rtl/tmac_regs.sv
// Module: tmac_regs
// CPU-visible register file: control register (direction, index, busy view)
// and the two 16-bit data staging registers, plus read-data selection.
// Assumes: single-cycle write strobes; the sequencer owns the busy flag.
module tmac_regs
    import tmac_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_mode,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_be,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              busy,
    input  logic              ld_en,
    input  logic [WORD_W-1:0] ld_word,
    output logic              start,
    output logic              ctrl_dir,
    output logic [IDX_W-1:0]  ctrl_idx,
    output logic [WORD_W-1:0] data_word
);
    logic [REG_W-1:0] upper_q, lower_q;
    logic             wr_any, ctrl_wr;

    // Write decode and control lock (active mode or transfer in flight)
    always_comb begin
        wr_any  = bus_sel && bus_wr;
        ctrl_wr = wr_any && bus_addr == OFS_CTRL && !active_mode && !busy;
        start   = ctrl_wr && bus_be[0];
    end

    // Control register: direction from the high byte, index from the low byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_dir <= 1'b0;
            ctrl_idx <= '0;
        end else if (ctrl_wr) begin
            if (bus_be[1]) ctrl_dir <= bus_wdata[CTL_DIR_BIT];
            if (bus_be[0]) ctrl_idx <= bus_wdata[IDX_W-1:0];
        end
    end

    // Byte-enable merge for a data register write
    function automatic logic [REG_W-1:0] merge(input logic [REG_W-1:0] old,
                                               input logic [REG_W-1:0] nw,
                                               input logic [1:0]       be);
        logic [REG_W-1:0] r;
        r = old;
        for (int b = 0; b < 2; b++) begin
            if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
        end
        return r;
    endfunction

    // Upper data register: table load wins over a CPU write; bit 5 never stored
    always_ff @(posedge clk) begin
        if (!rst_n)                                upper_q <= '0;
        else if (ld_en)                            upper_q <= ld_word[WORD_W-1:REG_W] & UPR_KEEP_MASK;
        else if (wr_any && bus_addr == OFS_UPPER)  upper_q <= merge(upper_q, bus_wdata, bus_be) & UPR_KEEP_MASK;
    end

    // Lower data register (time mark): table load wins over a CPU write
    always_ff @(posedge clk) begin
        if (!rst_n)                                lower_q <= '0;
        else if (ld_en)                            lower_q <= ld_word[REG_W-1:0];
        else if (wr_any && bus_addr == OFS_LOWER)  lower_q <= merge(lower_q, bus_wdata, bus_be);
    end

    assign data_word = {upper_q, lower_q};

    // Read-data selection by offset
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL: begin
                bus_rdata[CTL_DIR_BIT]  = ctrl_dir;
                bus_rdata[CTL_BUSY_BIT] = busy;
                bus_rdata[IDX_W-1:0]    = ctrl_idx;
            end
            OFS_UPPER: bus_rdata = upper_q;
            OFS_LOWER: bus_rdata = lower_q;
            default:   bus_rdata = '0;
        endcase
    end

    // R2: reserved control bits always read zero
    p_ctrl_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_CTRL) |-> (bus_rdata[CTL_BUSY_BIT-1:IDX_W] == '0))
        else $error("control reserved bits nonzero");

    // R3: a busy cycle is only ever preceded by a write carrying the low byte
    p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($past(bus_be[0]) && $past(wr_any) && $past(bus_addr) == OFS_CTRL))
        else $error("transfer started without low-byte control write");

    // R7: control fields hold while a control write arrives in active mode
    p_lock_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && bus_addr == OFS_CTRL && active_mode) |=> $stable({ctrl_dir, ctrl_idx}))
        else $error("control changed in active mode");

    // R5: a load places the table word into the staging pair
    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (data_word == ($past(ld_word) & {UPR_KEEP_MASK, {REG_W{1'b1}}})))
        else $error("data registers not loaded from table");

    // R11: reserved bit of the upper register stays zero
    p_rsvd_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !upper_q[UPR_RSVD_BIT])
        else $error("upper data reserved bit set");
endmodule

// File: rtl/tmac_top.sv
// Module: tmac_top
// Indirect trigger memory access controller: a 16-bit register window onto a
// DEPTH x 32-bit trigger table, with a locked-out write path in active mode
// and a combinational read port for the schedule logic.
// Assumes: active_mode comes synchronous to clk.
module tmac_top
    import tmac_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_mode,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_be,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [IDX_W-1:0]  sch_idx,
    output logic [WORD_W-1:0] sch_word
);
    logic              start, busy, mem_we, ld_en, ctrl_dir;
    logic [IDX_W-1:0]  ctrl_idx;
    logic [WORD_W-1:0] data_word, xfer_word;

    tmac_regs #(.IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .active_mode(active_mode),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .ld_en(ld_en), .ld_word(xfer_word),
        .start(start), .ctrl_dir(ctrl_dir), .ctrl_idx(ctrl_idx),
        .data_word(data_word)
    );

    tmac_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .dir(ctrl_dir),
        .active_mode(active_mode), .busy(busy), .mem_we(mem_we), .ld_en(ld_en)
    );

    tmac_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .lock(active_mode),
        .we(mem_we), .widx(ctrl_idx), .wword(data_word),
        .ridx_a(ctrl_idx), .rword_a(xfer_word),
        .ridx_b(sch_idx), .rword_b(sch_word)
    );

    // R12: index and direction stay fixed through the busy cycle
    p_ctrl_frozen_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable({ctrl_dir, ctrl_idx}))
        else $error("control changed during transfer");
endmodule

// File: tb/sim_tmac_top.sv
module sim_tmac_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        act = 1'b0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [1:0]  addr = 2'd0, be = 2'b00;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic [4:0]  sidx = 5'd0;
    logic [31:0] sword;
    int          n_chk = 0, n_fail = 0, cyc = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    tmac_top u0 (
        .clk(clk), .rst_n(rst_n), .active_mode(act),
        .bus_sel(sel), .bus_wr(wr), .bus_addr(addr), .bus_be(be),
        .bus_wdata(wdata), .bus_rdata(rdata), .sch_idx(sidx), .sch_word(sword)
    );

    // Vector fields: kind(2: 0 write,1 read-check) act(1) addr(2) be(2) data(16) req(4)
    localparam int NV = 22;
    localparam logic [26:0] VEC [NV] = '{
        {2'd0,1'b0,2'd1,2'b11,16'hA5E3,4'd11}, // write upper, bit5 set (R11)
        {2'd0,1'b0,2'd2,2'b11,16'h1234,4'd9},
        {2'd1,1'b0,2'd1,2'b00,16'hA5C3,4'd11}, // R11 bit5 dropped
        {2'd1,1'b0,2'd2,2'b00,16'h1234,4'd9},
        {2'd0,1'b0,2'd0,2'b11,16'h8007,4'd4},  // store to entry 7 (R4)
        {2'd1,1'b0,2'd0,2'b00,16'hC007,4'd6},  // R6 busy visible
        {2'd1,1'b0,2'd0,2'b00,16'h8007,4'd6},  // R6 busy gone, R2 layout
        {2'd0,1'b0,2'd1,2'b11,16'h0000,4'd9},
        {2'd0,1'b0,2'd2,2'b11,16'h0000,4'd9},
        {2'd0,1'b0,2'd0,2'b11,16'h0007,4'd5},  // load entry 7 (R5)
        {2'd1,1'b0,2'd0,2'b00,16'h4007,4'd6},
        {2'd1,1'b0,2'd1,2'b00,16'hA5C3,4'd5},  // R5 upper half
        {2'd1,1'b0,2'd2,2'b00,16'h1234,4'd5},  // R5 lower half
        {2'd0,1'b0,2'd0,2'b10,16'h8000,4'd3},  // high byte only (R3)
        {2'd1,1'b0,2'd0,2'b00,16'h8007,4'd3},  // R3 no busy
        {2'd0,1'b0,2'd1,2'b01,16'hFFFF,4'd9},  // low byte only (R9)
        {2'd1,1'b0,2'd1,2'b00,16'hA5DF,4'd9},
        {2'd1,1'b0,2'd2,2'b00,16'h1234,4'd3},  // R3 no load happened
        {2'd0,1'b1,2'd0,2'b11,16'h8003,4'd7},  // control write in active mode (R7)
        {2'd1,1'b1,2'd0,2'b00,16'h8007,4'd7},  // R7 unchanged, no busy
        {2'd0,1'b1,2'd2,2'b11,16'hBEEF,4'd9},  // R9 data write in active mode
        {2'd1,1'b1,2'd2,2'b00,16'hBEEF,4'd9}
    };

    function automatic logic [15:0] hi_of(input int i);
        return ((16'(i) * 16'h0913) ^ 16'h5A00) & 16'hFFDF;
    endfunction
    function automatic logic [15:0] lo_of(input int i);
        return 16'(i) * 16'h0101 + 16'h00F0;
    endfunction

    task automatic chk(input int req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr_op(input logic [1:0] a, input logic [1:0] b, input logic [15:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; be = b; wdata = d;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [15:0] exp, input int req);
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; addr = a;
        #1 chk(req, {16'h0, rdata}, {16'h0, exp});
    endtask

    task automatic idle();
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] keep7;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values on every offset
        for (int a = 0; a < 4; a++) rd_chk(2'(a), 16'h0000, 1);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            act = VEC[v][24];
            addr = VEC[v][23:22]; be = VEC[v][21:20]; wdata = VEC[v][19:4];
            sel = (VEC[v][26:25] == 2'd0); wr = sel;
            if (VEC[v][26:25] == 2'd1)
                #1 chk(int'(VEC[v][3:0]), {16'h0, rdata}, {16'h0, VEC[v][19:4]});
        end
        idle();
        act = 1'b0;

        // R4/R10: fill every entry, then read all through the schedule port
        for (int i = 0; i < 32; i++) begin
            wr_op(2'd1, 2'b11, hi_of(i));
            wr_op(2'd2, 2'b11, lo_of(i));
            wr_op(2'd0, 2'b11, {1'b1, 10'h0, 5'(i)});
            idle();
        end
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            sidx = 5'(i);
            #1 chk(10, sword, {hi_of(i), lo_of(i)}); // R10 and R4
        end

        // R8: active mode raised during the busy cycle blocks the store
        keep7 = {hi_of(7), lo_of(7)};
        wr_op(2'd1, 2'b11, 16'h0000);
        wr_op(2'd2, 2'b11, 16'h0000);
        wr_op(2'd0, 2'b11, 16'h8007);
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; act = 1'b1;
        idle();
        sidx = 5'd7;
        #1 chk(8, sword, keep7);
        act = 1'b0;
        // R8: same for a load: data registers keep zero
        wr_op(2'd0, 2'b11, 16'h0007);
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; act = 1'b1;
        rd_chk(2'd1, 16'h0000, 8);
        act = 1'b0;

        // R12: control write during busy is ignored; load of entry 3 proceeds
        wr_op(2'd0, 2'b11, 16'h0003);
        wr_op(2'd0, 2'b11, 16'h0009);
        idle();
        rd_chk(2'd0, 16'h0003, 12);
        rd_chk(2'd1, hi_of(3), 5);

        // R5 boundary: last entry 0x1F
        wr_op(2'd0, 2'b11, 16'h001F);
        idle();
        rd_chk(2'd2, lo_of(31), 5);
        rd_chk(2'd1, hi_of(31), 5);

        // R1: reset mid-run clears the registers again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_chk(2'd0, 16'h0000, 1);
        rd_chk(2'd2, 16'h0000, 1);
        finish_run();
    end
endmodule